// File: doc/BRIEF.md
# Device-Side Command Mailbox Registers

This block is the device end of a command mailbox that a host drives through a memory-mapped register window. Four resources share the window:

- a control word holding a doorbell bit;
- a 64-bit command word carrying an opcode and a payload length;
- a status word carrying a return code;
- a byte-addressable payload buffer of `CAP` bytes.

To issue a command, the host fills in the command word and the payload in any order while the doorbell is clear, then sets the doorbell. From that point the block owns every register.

After the doorbell is rung, the block hands the command to a firmware port with a one-cycle valid pulse. The firmware may read and write the payload one byte at a time, and it answers with a done pulse, a return code and an output length. The block commits the whole result on the edge that samples done. On that edge it stores the return code, replaces the length field with the output length clamped to `CAP`, and clears the doorbell. A return code of zero means success; for any other code the host disregards the length. Opcode 0x4000 (identify) carries an empty input payload. After commit, nothing changes until the next ring.

`CAP` must be a power of two, at least 256. The window is `$clog2(CAP)+1` bits of byte address. Registers sit in the lower half and the payload in the upper half, at byte address `CAP` + offset. Host accesses are 64-bit words with byte enables; reads are combinational.

Top module: `mbox_dev_regs`

## Requirements
- R1: After reset the doorbell, command word, status word and every payload byte read as zero.
- R2: A host write to byte address 0x00 with `reg_be[0]=1` and `reg_wdata[0]=1` while the doorbell is clear sets the doorbell (control bit 0). Writing 0 there has no effect. On the cycle after the ring, `fw_cmd_valid` is high for exactly one cycle, with `fw_opcode` and `fw_in_len` equal to the command fields.
- R3: The command word at byte address 0x08 holds the opcode in bits 15:0 and the length in bits 36:16. Bits 63:37 read 0, and each byte lane is written only when its `reg_be` bit is set.
- R4: A payload write to byte address `CAP`+8k stores byte lane b of `reg_wdata` into payload byte 8k+b when `reg_be[b]` is set. A read at that address returns those eight bytes, lane b from byte 8k+b.
- R5: While the doorbell is set, host writes to the control, command and payload locations are ignored, and a second ring produces no `fw_cmd_valid` pulse.
- R6: `fw_done` while the doorbell is set commits on that clock edge. From the next cycle, status bits 47:32 hold `fw_ret_code`, the command length field holds the output length, the opcode is unchanged and the doorbell reads 0. This holds for zero and nonzero return codes alike.
- R7: An `fw_out_len` above `CAP` is reported as exactly `CAP`. Values up to `CAP` are reported unchanged.
- R8: While the doorbell is clear, `fw_done` and firmware payload writes have no effect, so status, command and payload stay as committed until the host writes them or rings again.
- R9: While the doorbell is set, `fw_pay_rdata` shows the payload byte at `fw_pay_addr`, and `fw_pay_we` writes a byte there that the host reads after completion.
- R10: The status word at byte address 0x10 is read-only to the host; other words in the lower half read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Host write strobe |
| reg_addr | input | $clog2(CAP)+1 | Host byte address (8-byte aligned) |
| reg_be | input | 8 | Host byte enables |
| reg_wdata | input | 64 | Host write data |
| reg_rdata | output | 64 | Host read data of the addressed word |
| fw_cmd_valid | output | 1 | One-cycle pulse after a ring |
| fw_opcode | output | 16 | Opcode of the current command |
| fw_in_len | output | 21 | Input payload length of the current command |
| fw_done | input | 1 | Firmware completion pulse |
| fw_ret_code | input | 16 | Return code with done |
| fw_out_len | input | 21 | Output length with done |
| fw_pay_we | input | 1 | Firmware payload byte write |
| fw_pay_addr | input | $clog2(CAP) | Firmware payload byte index |
| fw_pay_wdata | input | 8 | Firmware payload write byte |
| fw_pay_rdata | output | 8 | Payload byte at fw_pay_addr |

## Verification
A host write or a done pulse applied in one low clock phase takes effect at the next rising edge. The doorbell, command, status and payload contents read back in the low phase that follows, and `fw_cmd_valid` is high in exactly that phase. The bench drives on falling edges and samples one time unit after a falling edge, so every check lands one cycle after its stimulus. It also confirms that the valid pulse is gone one further cycle later. Reads and `fw_pay_rdata` are combinational and are sampled in the same low phase as the address is applied. The bench also flags any command whose doorbell stays set longer than a configurable cycle budget, which stands in for the host's completion timeout.

// File: rtl/mbox_dev_regs.sv
module mbox_dev_regs #(
  parameter int CAP = 256,
  localparam int AW = $clog2(CAP) + 1,
  localparam int LW = 21
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [7:0]    reg_be,
  input  logic [63:0]   reg_wdata,
  output logic [63:0]   reg_rdata,
  output logic          fw_cmd_valid,
  output logic [15:0]   fw_opcode,
  output logic [LW-1:0] fw_in_len,
  input  logic          fw_done,
  input  logic [15:0]   fw_ret_code,
  input  logic [LW-1:0] fw_out_len,
  input  logic          fw_pay_we,
  input  logic [AW-2:0] fw_pay_addr,
  input  logic [7:0]    fw_pay_wdata,
  output logic [7:0]    fw_pay_rdata
);
  localparam logic [AW-5:0] W_CTRL = 0;
  localparam logic [AW-5:0] W_CMD  = 1;
  localparam logic [AW-5:0] W_STAT = 2;

  logic          db_q, valid_q;
  logic [15:0]   op_q, ret_q;
  logic [LW-1:0] len_q;
  logic [7:0]    pay_q [CAP];
  logic [63:0]   cmd_cur, cmd_new;

  wire            is_pay  = reg_addr[AW-1];
  wire [AW-5:0]   word    = reg_addr[AW-2:3];
  wire            host_ok = reg_we && !db_q;
  wire            ring    = host_ok && !is_pay && word == W_CTRL && reg_be[0] && reg_wdata[0];
  wire            cmd_wr  = host_ok && !is_pay && word == W_CMD;
  wire            commit  = db_q && fw_done;
  wire [LW-1:0]   out_clamped = (fw_out_len > LW'(CAP)) ? LW'(CAP) : fw_out_len;

  assign cmd_cur      = {27'd0, len_q, op_q};
  assign fw_cmd_valid = valid_q;
  assign fw_opcode    = op_q;
  assign fw_in_len    = len_q;
  assign fw_pay_rdata = pay_q[fw_pay_addr];

  always_comb begin
    for (int b = 0; b < 8; b++)
      cmd_new[8*b +: 8] = reg_be[b] ? reg_wdata[8*b +: 8] : cmd_cur[8*b +: 8];
  end

  always_comb begin
    reg_rdata = '0;
    if (is_pay) begin
      for (int b = 0; b < 8; b++)
        reg_rdata[8*b +: 8] = pay_q[{word, 3'(b)}];
    end else if (word == W_CTRL) begin
      reg_rdata[0] = db_q;
    end else if (word == W_CMD) begin
      reg_rdata = cmd_cur;
    end else if (word == W_STAT) begin
      reg_rdata[47:32] = ret_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      db_q    <= 1'b0;
      valid_q <= 1'b0;
      op_q    <= '0;
      len_q   <= '0;
      ret_q   <= '0;
    end else begin
      valid_q <= ring;
      if (ring) db_q <= 1'b1;
      if (cmd_wr) begin
        op_q  <= cmd_new[15:0];
        len_q <= cmd_new[36:16];
      end
      if (commit) begin
        db_q  <= 1'b0;
        ret_q <= fw_ret_code;
        len_q <= out_clamped;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < CAP; i++) pay_q[i] <= 8'd0;
    end else begin
      if (host_ok && is_pay) begin
        for (int b = 0; b < 8; b++)
          if (reg_be[b]) pay_q[{word, 3'(b)}] <= reg_wdata[8*b +: 8];
      end
      if (db_q && fw_pay_we) pay_q[fw_pay_addr] <= fw_pay_wdata;
    end
  end
endmodule

// File: rtl/mbox_dev_regs_chk.sv
module mbox_dev_regs_chk #(
  parameter int CAP = 256
) (
  input logic        clk,
  input logic        rst_n,
  input logic        db_q,
  input logic        valid_q,
  input logic        fw_done,
  input logic [15:0] op_q,
  input logic [15:0] ret_q,
  input logic [20:0] len_q
);
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) valid_q |=> !valid_q); // R2
  AST_VALID_AT_RING: assert property (@(posedge clk) disable iff (!rst_n) $rose(db_q) |-> valid_q); // R2
  AST_CMD_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (db_q && $past(db_q)) |-> ($stable(op_q) && $stable(len_q))); // R5
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (db_q && fw_done) |=> !db_q); // R6
  AST_OUT_LEN_CLAMP: assert property (@(posedge clk) disable iff (!rst_n) $fell(db_q) |-> (len_q <= 21'(CAP))); // R7
  AST_IDLE_STATUS_STABLE: assert property (@(posedge clk) disable iff (!rst_n) (!db_q && !$past(db_q)) |-> $stable(ret_q)); // R8
endmodule

bind mbox_dev_regs mbox_dev_regs_chk #(.CAP(CAP)) u_chk (
  .clk(clk), .rst_n(rst_n), .db_q(db_q), .valid_q(valid_q), .fw_done(fw_done),
  .op_q(op_q), .ret_q(ret_q), .len_q(len_q)
);

// File: tb/test_mbox_dev_regs.sv
`timescale 1ns/1ps
module test_mbox_dev_regs;
  localparam int CAP = 256;
  localparam int AW = $clog2(CAP) + 1;
  localparam int TIMEOUT_CYC = 500;
  localparam logic [AW-1:0] A_CTRL = 0, A_CMD = 8, A_STAT = 16;

  logic clk = 0, rst_n = 0;
  logic reg_we = 0;
  logic [AW-1:0] reg_addr = '0;
  logic [7:0] reg_be = '0;
  logic [63:0] reg_wdata = '0, reg_rdata;
  logic fw_cmd_valid;
  logic [15:0] fw_opcode;
  logic [20:0] fw_in_len;
  logic fw_done = 0;
  logic [15:0] fw_ret_code = '0;
  logic [20:0] fw_out_len = '0;
  logic fw_pay_we = 0;
  logic [AW-2:0] fw_pay_addr = '0;
  logic [7:0] fw_pay_wdata = '0, fw_pay_rdata;

  int tests = 0, fails = 0, busy_cnt = 0;
  logic exp_db = 0;
  logic [15:0] exp_op = 0, exp_ret = 0;
  logic [20:0] exp_len = 0;
  logic [7:0] exp_pay [CAP];

  always #5 clk = ~clk;

  mbox_dev_regs #(.CAP(CAP)) i_mbox_dev_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_be(reg_be),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fw_cmd_valid(fw_cmd_valid),
    .fw_opcode(fw_opcode), .fw_in_len(fw_in_len), .fw_done(fw_done),
    .fw_ret_code(fw_ret_code), .fw_out_len(fw_out_len), .fw_pay_we(fw_pay_we),
    .fw_pay_addr(fw_pay_addr), .fw_pay_wdata(fw_pay_wdata), .fw_pay_rdata(fw_pay_rdata)
  );

  function automatic logic [20:0] clamp(input logic [20:0] l);
    return (l > 21'(CAP)) ? 21'(CAP) : l;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (exp_db) begin
      busy_cnt <= busy_cnt + 1;
      if (busy_cnt == TIMEOUT_CYC) begin
        fails++;
        $display("FAIL timeout: doorbell set %0d cycles, expected at most %0d", busy_cnt, TIMEOUT_CYC);
      end
    end else busy_cnt <= 0;
  end

  task automatic host_wr(input logic [AW-1:0] a, input logic [63:0] d, input logic [7:0] be);
    logic [63:0] c;
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d; reg_be = be;
    @(negedge clk);
    reg_we = 0;
    if (!exp_db) begin
      if (a[AW-1]) begin
        for (int b = 0; b < 8; b++)
          if (be[b]) exp_pay[{a[AW-2:3], 3'b000} + b] = d[8*b +: 8];
      end else if (a == A_CTRL) begin
        if (be[0] && d[0]) exp_db = 1;
      end else if (a == A_CMD) begin
        c = {27'd0, exp_len, exp_op};
        for (int b = 0; b < 8; b++)
          if (be[b]) c[8*b +: 8] = d[8*b +: 8];
        exp_op = c[15:0]; exp_len = c[36:16];
      end
    end
  endtask

  task automatic host_rd(input logic [AW-1:0] a, output logic [63:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic ring(input string req);
    logic was_idle;
    was_idle = !exp_db;
    host_wr(A_CTRL, 64'd1, 8'h01);
    #1;
    check({req, " valid pulse"}, {63'd0, fw_cmd_valid}, {63'd0, was_idle});
    if (was_idle) begin
      check("R2 fw_opcode", {48'd0, fw_opcode}, {48'd0, exp_op});
      check("R2 fw_in_len", {43'd0, fw_in_len}, {43'd0, exp_len});
    end
    @(negedge clk); #1;
    check("R2 valid drops", {63'd0, fw_cmd_valid}, 64'd0);
  endtask

  task automatic fw_wr(input logic [AW-2:0] a, input logic [7:0] d);
    @(negedge clk);
    fw_pay_we = 1; fw_pay_addr = a; fw_pay_wdata = d;
    @(negedge clk);
    fw_pay_we = 0;
    if (exp_db) exp_pay[a] = d;
  endtask

  task automatic fw_finish(input logic [15:0] rc, input logic [20:0] ol);
    @(negedge clk);
    fw_done = 1; fw_ret_code = rc; fw_out_len = ol;
    @(negedge clk);
    fw_done = 0;
    if (exp_db) begin
      exp_ret = rc; exp_len = clamp(ol); exp_db = 0;
    end
  endtask

  task automatic verify_all(input string req);
    logic [63:0] d;
    host_rd(A_CTRL, d); check({req, " ctrl"}, d, {63'd0, exp_db});
    host_rd(A_CMD, d);  check({req, " cmd"}, d, {27'd0, exp_len, exp_op});
    host_rd(A_STAT, d); check({req, " status"}, d, {16'd0, exp_ret, 32'd0});
    for (int w = 0; w < CAP / 8; w++) begin
      logic [63:0] e;
      host_rd(AW'(CAP + 8 * w), d);
      for (int b = 0; b < 8; b++) e[8*b +: 8] = exp_pay[8 * w + b];
      check({req, " payload"}, d, e);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [63:0] d;
    void'($urandom(32'd1234));
    for (int i = 0; i < CAP; i++) exp_pay[i] = 8'd0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    verify_all("R1 reset");

    host_wr(A_CTRL, 64'd0, 8'hFF);
    verify_all("R2 write zero to doorbell");
    host_wr(A_CMD, 64'hFFFF_FFFF_FFFF_FFFF, 8'h01);
    verify_all("R3 byte enable lane0");
    host_wr(A_CMD, {27'd0, 21'd0, 16'h4000}, 8'hFF);
    verify_all("R3 identify command");
    host_wr(A_STAT, 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF);
    host_wr(AW'(24), 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF);
    host_rd(AW'(24), d); check("R10 unused word", d, 64'd0);
    verify_all("R10 status read-only");
    host_wr(AW'(CAP + 16), 64'h8877_6655_4433_2211, 8'hA5);
    verify_all("R4 payload byte enables");

    ring("R2");
    check("R2 identify opcode", {48'd0, fw_opcode}, 64'h4000);
    fw_pay_addr = 8'd16; #1;
    check("R9 fw reads payload", {56'd0, fw_pay_rdata}, {56'd0, exp_pay[16]});
    host_wr(A_CMD, 64'h1234_5678, 8'hFF);
    host_wr(AW'(CAP), 64'hDEAD_BEEF_DEAD_BEEF, 8'hFF);
    ring("R5 ring while busy");
    verify_all("R5 writes ignored while busy");
    fw_wr(8'd3, 8'h5A);
    fw_finish(16'h0000, 21'd64);
    verify_all("R6 success commit");

    fw_finish(16'h00AA, 21'd5);
    fw_wr(8'd4, 8'h77);
    verify_all("R8 idle done and fw write ignored");

    ring("R7");
    fw_finish(16'h0000, 21'(CAP + 5));
    verify_all("R7 clamp above capacity");
    ring("R7");
    fw_finish(16'h0000, 21'(CAP));
    verify_all("R7 exact capacity");
    ring("R6");
    fw_finish(16'h0013, 21'd9);
    verify_all("R6 error code commit");

    for (int it = 0; it < 30; it++) begin
      logic [15:0] op;
      logic [20:0] ln, ol;
      logic [15:0] rc;
      op = 16'($urandom);
      ln = 21'($urandom_range(0, CAP));
      if (it % 2 == 0) host_wr(A_CMD, {27'd0, ln, op}, 8'hFF);
      for (int k = 0; k < 3; k++)
        host_wr(AW'(CAP + 8 * $urandom_range(0, CAP / 8 - 1)), {$urandom, $urandom}, 8'($urandom));
      if (it % 2 == 1) host_wr(A_CMD, {27'd0, ln, op}, 8'hFF);
      ring("R2 random");
      fw_pay_addr = (AW-1)'($urandom); #1;
      check("R9 random fw read", {56'd0, fw_pay_rdata}, {56'd0, exp_pay[fw_pay_addr]});
      if ($urandom_range(0, 1) == 1)
        host_wr(AW'(CAP + 8 * $urandom_range(0, CAP / 8 - 1)), {$urandom, $urandom}, 8'hFF);
      fw_wr((AW-1)'($urandom), 8'($urandom));
      repeat ($urandom_range(0, 5)) @(negedge clk);
      rc = ($urandom_range(0, 3) == 0) ? 16'($urandom) : 16'h0;
      ol = 21'($urandom_range(0, 2 * CAP));
      fw_finish(rc, ol);
      verify_all("R6 R7 R9 random command");
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule